// File: doc/BRIEF.md
# Crystal Kick Drive Controller

This block starts a watch-crystal resonator and keeps it ringing using nothing but full-rail drive on a tri-state pin. The sense and drive functions sit on separate pins, so the controller never reads the pin it is driving. It first drives a square wave whose half-period is a programmed number of clock ticks, for a programmed burst length. It then releases the pin and waits a programmed settle time. After that it counts threshold crossings on the sense input. Once enough consecutive crossings arrive, each within the watchdog window, it enters the sustain phase.

In the sustain phase every accepted crossing fires one short kick toward the rail in the direction of that crossing: high after a rising crossing, low after a falling one. High and low kicks use the same programmed width, so the average drive stays at mid-supply. Outside a kick the pin is high impedance. A crossing that arrives while a kick is still active is dropped.

A watchdog restarts the start-up phase whenever crossings stop and counts each restart. A failed qualification also lengthens the start-up half-period by a programmed step, so the excitation frequency walks slowly toward resonance. After a programmed number of restarts the controller parks in a fault state.

The states and their transitions are:
- IDLE to STARTUP when `enable` rises.
- STARTUP to RELEASE when the burst ends.
- RELEASE to SUSTAIN once it has qualified.
- RELEASE to STARTUP or FAULT on a watchdog timeout.
- SUSTAIN to STARTUP or FAULT on a watchdog timeout.
- Any state to IDLE when `enable` is low.

Top module: `xtal_kick_ctrl`

## Requirements
- R1: After reset the controller is in IDLE: `state_o` reads 0, `drv_en` is 0 and `restarts_o` is 0.
- R2: While `enable` is high in IDLE, the next clock enters STARTUP. `drv_en` is then 1, and `drv_level` is 1 for the first half-period ticks, after which it toggles every half-period ticks. `restarts_o` is cleared and the half-period is loaded from `cfg_half_period`.
- R3: After exactly `cfg_burst_len` cycles in STARTUP the controller enters RELEASE, and `drv_en` stays 0 throughout RELEASE.
- R4: In RELEASE, crossings seen during the first `cfg_settle_len` cycles are not counted. After that, the crossing that completes `cfg_lock_count` counted crossings moves the controller to SUSTAIN.
- R5: In SUSTAIN, a change of `sense_in` is seen as a crossing, and 2 cycles later `drv_en` is 1 for exactly `cfg_pulse_width` cycles. `drv_level` is 1 for a rising crossing and 0 for a falling one, and is held steady during the kick. Between kicks `drv_en` is 0.
- R6: A crossing detected while a kick is active produces no kick, does not lengthen the active kick, and does not restart the watchdog.
- R7: If no crossing is accepted for `cfg_timeout` cycles in SUSTAIN, or in RELEASE after settling, `restarts_o` increments by 1. The controller then re-enters STARTUP unless the new count equals `cfg_max_restarts`.
- R8: A watchdog timeout in RELEASE adds `cfg_period_step` to the half-period used by the next STARTUP. A timeout in SUSTAIN leaves the half-period unchanged.
- R9: When the incremented restart count equals `cfg_max_restarts`, the controller enters FAULT with `drv_en` at 0 and stays there while `enable` is high.
- R10: When `enable` is low, the controller is in IDLE one clock later, from any state.
- R11: `state_o` encodes the state as IDLE=0, STARTUP=1, RELEASE=2, SUSTAIN=3 and FAULT=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request; low forces IDLE |
| cfg_half_period | input | CW | Initial start-up half-period in ticks (at least 1) |
| cfg_period_step | input | CW | Half-period increment after a failed qualification |
| cfg_burst_len | input | TW | Start-up burst length in ticks (at least 1) |
| cfg_settle_len | input | TW | Release settle time in ticks (at least 1) |
| cfg_pulse_width | input | CW | Sustain kick width in ticks (at least 1) |
| cfg_timeout | input | TW | Watchdog window in ticks (at least 1) |
| cfg_lock_count | input | NW | Crossings needed to enter SUSTAIN (at least 1) |
| cfg_max_restarts | input | NW | Restart count that forces FAULT (at least 1) |
| sense_in | input | 1 | Asynchronous threshold comparator output |
| drv_en | output | 1 | Drive enable; 0 means the pin is high impedance |
| drv_level | output | 1 | Rail driven while `drv_en` is 1 |
| state_o | output | 3 | Current state code |
| restarts_o | output | NW | Watchdog restarts since leaving IDLE |

## Verification
A change of `sense_in` reaches the state machine two edges after the edge that first samples it. A state change or a kick therefore appears on the ports at the third falling edge after the falling edge where the bench drove the input. Every sense-driven check counts falling edges from that drive point. Start-up waveform checks start at the first falling edge where STARTUP is visible, and sample index i expects level `(i / half_period)` even. Watchdog checks compare one edge before and one edge after the exact expiry, which falls `cfg_timeout` edges after the last accepted crossing.

// File: rtl/xkc_pkg.sv
package xkc_pkg;
    typedef enum logic [2:0] {
        XK_IDLE    = 3'd0,
        XK_START   = 3'd1,
        XK_RELEASE = 3'd2,
        XK_SUSTAIN = 3'd3,
        XK_FAULT   = 3'd4
    } xk_state_t;
endpackage

// File: rtl/xkc_sense_edge.sv
// Synchronizer chain for the comparator input plus crossing detector.
module xkc_sense_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sense,
    output logic rise,
    output logic fall
);
    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LEN-2:0], sense};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
    assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/xkc_square_gen.sv
// Start-up square wave: begins high, toggles every half_period ticks.
module xkc_square_gen #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] half_period,
    output logic          level
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            level <= 1'b1;
        end else if (!run) begin
            cnt   <= '0;
            level <= 1'b1;
        end else if (cnt == half_period - 1'b1) begin
            cnt   <= '0;
            level <= ~level;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/xkc_kick_timer.sv
// One kick of programmed width toward the requested rail.
module xkc_kick_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          fire,
    input  logic          dir,
    input  logic [CW-1:0] width,
    output logic          busy,
    output logic          level
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            level <= 1'b0;
        end else if (!arm) begin
            cnt <= '0;
        end else if (fire && cnt == '0) begin
            cnt   <= width;
            level <= dir;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/xtal_kick_ctrl.sv
module xtal_kick_ctrl
    import xkc_pkg::*;
#(
    parameter int CW          = 16,
    parameter int TW          = 24,
    parameter int NW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [CW-1:0] cfg_half_period,
    input  logic [CW-1:0] cfg_period_step,
    input  logic [TW-1:0] cfg_burst_len,
    input  logic [TW-1:0] cfg_settle_len,
    input  logic [CW-1:0] cfg_pulse_width,
    input  logic [TW-1:0] cfg_timeout,
    input  logic [NW-1:0] cfg_lock_count,
    input  logic [NW-1:0] cfg_max_restarts,
    input  logic          sense_in,
    output logic          drv_en,
    output logic          drv_level,
    output logic [2:0]    state_o,
    output logic [NW-1:0] restarts_o
);
    xk_state_t     state, state_n;
    logic [TW-1:0] tmr, tmr_n;
    logic [NW-1:0] qual, qual_n;
    logic [NW-1:0] restarts, restarts_n;
    logic [CW-1:0] cur_hp, cur_hp_n;
    logic          settled, settled_n;

    logic rise, fall, crossing;
    logic sq_level, kick_busy, kick_level, kick_fire;
    logic wd_expired;
    logic [NW-1:0] restarts_inc, qual_inc;

    xkc_sense_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sense (sense_in),
        .rise  (rise),
        .fall  (fall)
    );

    xkc_square_gen #(.CW(CW)) u_square (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (state == XK_START),
        .half_period (cur_hp),
        .level       (sq_level)
    );

    xkc_kick_timer #(.CW(CW)) u_kick (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (state == XK_SUSTAIN),
        .fire  (kick_fire),
        .dir   (rise),
        .width (cfg_pulse_width),
        .busy  (kick_busy),
        .level (kick_level)
    );

    assign crossing     = rise | fall;
    assign kick_fire    = (state == XK_SUSTAIN) && crossing && !kick_busy;
    assign wd_expired   = (tmr == cfg_timeout - 1'b1);
    assign restarts_inc = restarts + 1'b1;
    assign qual_inc     = qual + 1'b1;

    // Next-state and counter logic
    always_comb begin
        state_n    = state;
        tmr_n      = tmr + 1'b1;
        qual_n     = qual;
        restarts_n = restarts;
        cur_hp_n   = cur_hp;
        settled_n  = settled;
        unique case (state)
            XK_IDLE: begin
                tmr_n = '0;
                if (enable) begin
                    state_n    = XK_START;
                    cur_hp_n   = cfg_half_period;
                    restarts_n = '0;
                end
            end
            XK_START: begin
                if (tmr == cfg_burst_len - 1'b1) begin
                    state_n   = XK_RELEASE;
                    tmr_n     = '0;
                    settled_n = 1'b0;
                    qual_n    = '0;
                end
            end
            XK_RELEASE: begin
                if (!settled) begin
                    if (tmr == cfg_settle_len - 1'b1) begin
                        settled_n = 1'b1;
                        tmr_n     = '0;
                    end
                end else if (crossing) begin
                    tmr_n = '0;
                    if (qual_inc == cfg_lock_count) begin
                        state_n = XK_SUSTAIN;
                        qual_n  = '0;
                    end else begin
                        qual_n = qual_inc;
                    end
                end else if (wd_expired) begin
                    tmr_n      = '0;
                    restarts_n = restarts_inc;
                    cur_hp_n   = cur_hp + cfg_period_step;
                    state_n    = (restarts_inc == cfg_max_restarts) ? XK_FAULT : XK_START;
                end
            end
            XK_SUSTAIN: begin
                if (kick_fire) begin
                    tmr_n = '0;
                end else if (wd_expired) begin
                    tmr_n      = '0;
                    restarts_n = restarts_inc;
                    state_n    = (restarts_inc == cfg_max_restarts) ? XK_FAULT : XK_START;
                end
            end
            XK_FAULT: begin
                tmr_n = '0;
            end
            default: begin
                state_n = XK_IDLE;
                tmr_n   = '0;
            end
        endcase
        if (!enable) begin
            state_n = XK_IDLE;
            tmr_n   = '0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= XK_IDLE;
            tmr      <= '0;
            qual     <= '0;
            restarts <= '0;
            cur_hp   <= '0;
            settled  <= 1'b0;
        end else begin
            state    <= state_n;
            tmr      <= tmr_n;
            qual     <= qual_n;
            restarts <= restarts_n;
            cur_hp   <= cur_hp_n;
            settled  <= settled_n;
        end
    end

    // Outputs
    always_comb begin
        drv_en    = 1'b0;
        drv_level = 1'b0;
        unique case (state)
            XK_START: begin
                drv_en    = 1'b1;
                drv_level = sq_level;
            end
            XK_SUSTAIN: begin
                drv_en    = kick_busy;
                drv_level = kick_busy & kick_level;
            end
            default: begin
                drv_en    = 1'b0;
                drv_level = 1'b0;
            end
        endcase
        state_o    = state;
        restarts_o = restarts;
    end
endmodule

// File: rtl/xkc_checker.sv
module xkc_checker #(
    parameter int CW = 16,
    parameter int NW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic [CW-1:0] cfg_pulse_width,
    input logic          drv_en,
    input logic          drv_level,
    input logic [2:0]    state_o,
    input logic [NW-1:0] restarts_o
);
    logic [CW-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            run_len <= '0;
        else if (state_o == 3'd3 && drv_en)    run_len <= run_len + 1'b1;
        else                                   run_len <= '0;
    end

    p_startup_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 3'd1 |-> drv_en);

    p_hiz_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 || state_o == 3'd0) |-> !drv_en);

    p_kick_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3 && $past(state_o) == 3'd3 && drv_en && $past(drv_en))
            |-> $stable(drv_level));

    p_kick_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3 && $past(state_o) == 3'd3 && $fell(drv_en))
            |-> run_len == cfg_pulse_width);

    p_restart_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && $past(state_o) != 3'd1 && $past(state_o) != 3'd0)
            |-> restarts_o == $past(restarts_o) + 1'b1);

    p_fault_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 3'd4 |-> !drv_en);

    p_disable_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> state_o == 3'd0);

    p_legal_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd4);
endmodule

bind xtal_kick_ctrl xkc_checker #(.CW(CW), .NW(NW)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .enable          (enable),
    .cfg_pulse_width (cfg_pulse_width),
    .drv_en          (drv_en),
    .drv_level       (drv_level),
    .state_o         (state_o),
    .restarts_o      (restarts_o)
);

// File: tb/xtal_kick_ctrl_bench.sv
`timescale 1ns/1ps
module xtal_kick_ctrl_bench;
    localparam int CW = 16;
    localparam int TW = 24;
    localparam int NW = 8;
    localparam int HP = 4, STEP = 2, BURST = 20, SETTLE = 8;
    localparam int WIDTH = 3, TMO = 30, LOCK = 3, MAXR = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          sense = 1'b0;
    logic          drv_en, drv_level;
    logic [2:0]    state_o;
    logic [NW-1:0] restarts_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    xtal_kick_ctrl #(.CW(CW), .TW(TW), .NW(NW)) u_xtal_kick_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .enable           (enable),
        .cfg_half_period  (CW'(HP)),
        .cfg_period_step  (CW'(STEP)),
        .cfg_burst_len    (TW'(BURST)),
        .cfg_settle_len   (TW'(SETTLE)),
        .cfg_pulse_width  (CW'(WIDTH)),
        .cfg_timeout      (TW'(TMO)),
        .cfg_lock_count   (NW'(LOCK)),
        .cfg_max_restarts (NW'(MAXR)),
        .sense_in         (sense),
        .drv_en           (drv_en),
        .drv_level        (drv_level),
        .state_o          (state_o),
        .restarts_o       (restarts_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_state(input int s, input int limit, input string tag);
        int n = 0;
        while (int'(state_o) != s && n < limit) begin
            @(negedge clk);
            n++;
        end
        chk(tag, int'(state_o), s);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 state", int'(state_o), 0);
        chk("R1 drv_en", int'(drv_en), 0);
        chk("R1 restarts", int'(restarts_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_startup();
        enable = 1'b1;
        @(negedge clk);
        chk("R2 R11 enter startup", int'(state_o), 1);
        for (int i = 0; i < BURST; i++) begin
            chk("R2 drv_en", int'(drv_en), 1);
            chk("R2 square level", int'(drv_level), ((i / HP) % 2 == 0) ? 1 : 0);
            @(negedge clk);
        end
        chk("R3 R11 release after burst", int'(state_o), 2);
        chk("R3 hiz in release", int'(drv_en), 0);
    endtask

    task automatic t_qualify();
        sense = 1'b1;                      // inside settle window: not counted
        repeat (10) @(negedge clk);
        sense = 1'b0;
        repeat (4) @(negedge clk);
        chk("R4 one counted", int'(state_o), 2);
        sense = 1'b1;
        repeat (4) @(negedge clk);
        chk("R4 settle crossing ignored", int'(state_o), 2);
        chk("R3 hiz while qualifying", int'(drv_en), 0);
        sense = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 R11 sustain entered", int'(state_o), 3);
    endtask

    task automatic kick(input logic dir);
        sense = dir;
        repeat (2) begin
            @(negedge clk);
            chk("R5 no early kick", int'(drv_en), 0);
        end
        repeat (WIDTH) begin
            @(negedge clk);
            chk("R5 kick active", int'(drv_en), 1);
            chk("R5 kick level", int'(drv_level), int'(dir));
        end
        @(negedge clk);
        chk("R5 hiz after kick", int'(drv_en), 0);
    endtask

    task automatic t_pulses();
        kick(1'b1);
        kick(1'b0);
    endtask

    task automatic t_ignore_and_timeout();
        sense = 1'b1;
        @(negedge clk);                    // count 1
        sense = 1'b0;                      // lands while kick is active
        @(negedge clk);                    // count 2
        chk("R6 no kick yet", int'(drv_en), 0);
        for (int c = 3; c <= 5; c++) begin
            @(negedge clk);
            chk("R6 high kick", int'(drv_en), 1);
            chk("R6 high level", int'(drv_level), 1);
        end
        for (int c = 6; c <= 10; c++) begin
            @(negedge clk);
            chk("R6 dropped crossing gives no kick", int'(drv_en), 0);
        end
        repeat (22) @(negedge clk);        // count 32
        chk("R7 still sustain before expiry", int'(state_o), 3);
        @(negedge clk);                    // count 33
        chk("R7 restart into startup", int'(state_o), 1);
        chk("R7 restart count", int'(restarts_o), 1);
    endtask

    task automatic t_step();
        wait_state(2, 100, "R8 release reached");
        wait_state(1, 100, "R7 release timeout restarts");
        chk("R7 restart count two", int'(restarts_o), 2);
        for (int i = 0; i < 3 * (HP + STEP); i++) begin
            chk("R8 stepped half-period", int'(drv_level),
                ((i / (HP + STEP)) % 2 == 0) ? 1 : 0);
            @(negedge clk);
        end
    endtask

    task automatic t_fault();
        wait_state(4, 200, "R9 fault reached");
        chk("R9 restart count at limit", int'(restarts_o), MAXR);
        chk("R9 hiz in fault", int'(drv_en), 0);
        repeat (40) @(negedge clk);
        chk("R9 fault is sticky", int'(state_o), 4);
        chk("R9 still hiz", int'(drv_en), 0);
    endtask

    task automatic t_disable();
        enable = 1'b0;
        @(negedge clk);
        chk("R10 idle from fault", int'(state_o), 0);
        enable = 1'b1;
        @(negedge clk);
        chk("R2 restart from idle", int'(state_o), 1);
        chk("R2 restarts cleared", int'(restarts_o), 0);
        repeat (5) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R10 idle from startup", int'(state_o), 0);
        chk("R10 hiz in idle", int'(drv_en), 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_startup();
        t_qualify();
        t_pulses();
        t_ignore_and_timeout();
        t_step();
        t_fault();
        t_disable();
        finish_run();
    end
endmodule